// File: doc/BRIEF.md
# Batched Register-Access Command Engine

This block sits on the controller side of a host-to-controller mailbox. When the host posts a command whose code is 0xFF, the engine takes the packed byte stream in the mailbox write buffer and executes up to five register accesses against a byte-wide register space. That space has 16-bit addresses. A 4-bit sub-command selects the layout of every entry in the stream: plain write, plain read, or masked read-modify-write. The command's size field gives the number of valid bytes in the stream.

The engine first checks the stream as a whole. If the check passes, it walks the entries in buffer order and drives a simple register bus. A small register-file model inside the block answers that bus. For reads, each returned byte lands in the read buffer at a position that keeps the request's entry spacing. When the last access is finished, the engine raises a one-cycle completion pulse together with an error flag and an error code. A command that fails the check completes at once and touches no register.

Top module: `regcmd_engine`

## Requirements
- R1: With sub-command 0 (write), each entry is 3 bytes: address low byte at entry offset 0, address high byte at offset 1, data at offset 2. The data byte is stored in the addressed register.
- R2: With sub-command 1 (read), each entry is 2 bytes (address low, then address high). The value of read entry n appears at read-buffer byte offset 2 + 3n. Read-buffer byte k occupies bits [8k+7:8k]. Every other read-buffer byte is 0x00 once a command has been accepted.
- R3: With sub-command 2 (read-modify-write), each entry is 4 bytes: address low, address high, value, mask. The register becomes (old & ~mask) | (value & mask).
- R4: The entry count is size / entry width. A size that leaves a remainder, or that gives more than 5 entries, completes with err_flag = 1 and err_code = 0x01 and changes no register. A size of 0 completes with no access and no error.
- R5: A sub-command of 3 or above completes with err_flag = 1 and err_code = 0x02, whatever the size, and changes no register. A successful command reports err_flag = 0 and err_code = 0x00.
- R6: A start whose command code is not 0xFF is ignored: no busy, no done pulse, and the registers and read buffer are left unchanged.
- R7: Entries run in buffer order, so later entries see the effect of earlier entries in the same command (the last write to an address wins, and successive read-modify-writes build on each other).
- R8: A command is accepted on the clock edge that samples start with busy low. done is high for exactly one cycle, and it is high in cycle 1 + A after acceptance. A is the number of entries for write or read, twice that for read-modify-write, and 0 for a rejected command. busy is high from acceptance up to and including the done cycle, and err_flag and err_code are valid while done is high.
- R9: The register space holds 2^REG_AW bytes, all reset to 0x00, at addresses whose upper bits [15:REG_AW] match REG_BASE (0x5A00 by default). Reads outside this window return 0x00 and writes outside it are dropped.
- R10: After reset, busy, done and err_flag are 0, err_code is 0x00 and the read buffer is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command posted; sampled when busy is low |
| cmd_code | input | 8 | Message code; only 0xFF is acted on |
| sub_cmd | input | 4 | 0 write, 1 read, 2 read-modify-write |
| size | input | 8 | Number of valid bytes in the write buffer |
| wbuf | input | WBUF_BYTES*8 | Mailbox write buffer, byte k at bits [8k+7:8k] |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Command failed |
| err_code | output | 8 | 0x00 ok, 0x01 bad size, 0x02 bad sub-command |
| rbuf | output | RBUF_BYTES*8 | Read buffer, byte k at bits [8k+7:8k] |

## Verification
The size check is swept exhaustively: every size from 0 to 24 is tried under each of the three entry layouts and one unknown sub-command. This separates remainders from exact multiples, and the five-entry limit from the sizes just above it, and it confirms that the unknown-code error takes priority over a bad size. The valid batches carry pseudo-random addresses. Most of them fall inside the register window and a few fall outside it, and the values and masks are random too, so a wrong entry stride, a wrong address byte order or a wrong merge shows up as a mismatch when the registers are read back. Directed batches that hit the same address several times check the ordering. Masks of all zeros and all ones mark the ends of the merge. Read-back sweeps of the whole window, run after each group of commands, show that rejected and ignored commands left every register unchanged.

// File: rtl/regcmd_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the batched register-access command engine.
// Assumes entry widths never exceed 4 bytes.
package regcmd_pkg;

    localparam logic [7:0] CMD_REGACC = 8'hFF;

    localparam logic [3:0] SUB_WR  = 4'd0;
    localparam logic [3:0] SUB_RD  = 4'd1;
    localparam logic [3:0] SUB_RMW = 4'd2;

    localparam logic [7:0] ERR_NONE = 8'h00;
    localparam logic [7:0] ERR_SIZE = 8'h01;
    localparam logic [7:0] ERR_SUB  = 8'h02;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_MERGE,
        ST_FINISH
    } eng_state_e;

    // Byte width of one entry for a given sub-command (0 when unknown).
    function automatic logic [2:0] entry_width(input logic [3:0] sub);
        case (sub)
            SUB_WR:  return 3'd3;
            SUB_RD:  return 3'd2;
            SUB_RMW: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/regcmd_decode.sv
`timescale 1ns/1ps
// Command decoder: turns sub-command and byte size into an entry count
// and an error code. Purely combinational; it assumes the size is at most 8 bits.
module regcmd_decode
    import regcmd_pkg::*;
#(
    parameter int MAX_ENT = 5,
    parameter int CNT_W   = 3
) (
    input  logic [3:0]       sub,
    input  logic [7:0]       size,
    output logic [CNT_W-1:0] count,
    output logic [7:0]       code
);

    localparam logic [7:0] MAX_ENT_B = 8'(MAX_ENT);

    logic [7:0] quo;
    logic [7:0] rem;

    // Divide the size by the entry width of the sub-command, then judge the result.
    always_comb begin
        quo  = 8'd0;
        rem  = 8'd0;
        code = ERR_NONE;
        case (sub)
            SUB_WR: begin
                quo = size / 8'd3;
                rem = size % 8'd3;
            end
            SUB_RD: begin
                quo = {1'b0, size[7:1]};
                rem = {7'd0, size[0]};
            end
            SUB_RMW: begin
                quo = {2'b00, size[7:2]};
                rem = {6'd0, size[1:0]};
            end
            default: code = ERR_SUB;
        endcase
        if (code == ERR_NONE && (rem != 8'd0 || quo > MAX_ENT_B)) begin
            code = ERR_SIZE;
        end
    end

    // Count is only meaningful when code is ERR_NONE.
    assign count = (quo > MAX_ENT_B) ? '0 : quo[CNT_W-1:0];

endmodule

// File: rtl/regcmd_regfile.sv
`timescale 1ns/1ps
// Register-space model: 2^AW bytes mapped at a window selected by BASE.
// Combinational read and synchronous write. Accesses outside the window read
// zero and write nothing. Assumes at most one access per cycle.
module regcmd_regfile #(
    parameter int          AW   = 5,
    parameter logic [15:0] BASE = 16'h5A00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        re,
    input  logic        we,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];
    logic       hit;

    assign hit   = (addr[15:AW] == BASE[15:AW]);
    assign rdata = (re && hit) ? mem[addr[AW-1:0]] : 8'h00;

    // Clear the storage on reset and accept in-window writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) begin
                mem[j] <= 8'h00;
            end
        end else if (we && hit) begin
            mem[addr[AW-1:0]] <= wdata;
        end
    end

    // R9: a write outside the window leaves the aliased location untouched.
    a_r9_outside_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !hit) |=> (mem[$past(addr[AW-1:0])] == $past(mem[addr[AW-1:0]])));

endmodule

// File: rtl/regcmd_seq.sv
`timescale 1ns/1ps
// Entry sequencer: latches the write buffer on acceptance, walks the entries
// in order, drives one register-bus access per cycle (two for read-modify-write),
// fills the read buffer and reports completion. Assumes the decoder result
// belongs to the same cycle as the accepted start.
module regcmd_seq
    import regcmd_pkg::*;
#(
    parameter int WBUF_BYTES = 20,
    parameter int RBUF_BYTES = 16,
    parameter int CNT_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic [3:0]              sub,
    input  logic [CNT_W-1:0]        dec_count,
    input  logic [7:0]              dec_code,
    input  logic [WBUF_BYTES*8-1:0] wbuf,
    output logic                    bus_re,
    output logic                    bus_we,
    output logic [15:0]             bus_addr,
    output logic [7:0]              bus_wdata,
    input  logic [7:0]              bus_rdata,
    output logic                    busy,
    output logic                    done,
    output logic                    err_flag,
    output logic [7:0]              err_code,
    output logic [RBUF_BYTES*8-1:0] rbuf
);

    eng_state_e       state;
    logic [3:0]       sub_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idx;
    logic [7:0]       hold;
    logic [7:0]       wb [WBUF_BYTES];
    logic [7:0]       rb [RBUF_BYTES];
    logic [2:0]       width_q;
    logic [7:0]       ent [4];
    logic             last;
    logic             is_read;
    logic             is_wr;
    logic             is_rmw;

    assign width_q = entry_width(sub_q);
    assign is_read = (sub_q == SUB_RD);
    assign is_wr   = (sub_q == SUB_WR);
    assign is_rmw  = (sub_q == SUB_RMW);
    assign last    = (idx == cnt - CNT_W'(1));

    // Pick the four bytes of the current entry out of the latched buffer.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            ent[k] = 8'h00;
            for (int j = 0; j < WBUF_BYTES; j++) begin
                if (j == int'(idx) * int'(width_q) + k) begin
                    ent[k] = wb[j];
                end
            end
        end
    end

    // Drive the register bus from the current entry and phase.
    always_comb begin
        bus_addr  = {ent[1], ent[0]};
        bus_re    = (state == ST_ACCESS) && !is_wr;
        bus_we    = ((state == ST_ACCESS) && is_wr) || (state == ST_MERGE);
        bus_wdata = (state == ST_MERGE) ? ((hold & ~ent[3]) | (ent[2] & ent[3]))
                                        : ent[2];
    end

    // Control: acceptance, entry stepping, phase changes and error reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sub_q    <= 4'd0;
            cnt      <= '0;
            idx      <= '0;
            err_flag <= 1'b0;
            err_code <= ERR_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        sub_q    <= sub;
                        cnt      <= dec_count;
                        idx      <= '0;
                        err_flag <= (dec_code != ERR_NONE);
                        err_code <= dec_code;
                        state    <= (dec_code != ERR_NONE || dec_count == '0)
                                    ? ST_FINISH : ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (is_rmw) begin
                        state <= ST_MERGE;
                    end else if (last) begin
                        state <= ST_FINISH;
                    end else begin
                        idx <= idx + CNT_W'(1);
                    end
                end
                ST_MERGE: begin
                    if (last) begin
                        state <= ST_FINISH;
                    end else begin
                        idx   <= idx + CNT_W'(1);
                        state <= ST_ACCESS;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Data: latch the write buffer, clear and fill the read buffer, keep the old value for a merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= 8'h00;
            for (int j = 0; j < WBUF_BYTES; j++) wb[j] <= 8'h00;
            for (int j = 0; j < RBUF_BYTES; j++) rb[j] <= 8'h00;
        end else if (state == ST_IDLE && accept) begin
            for (int j = 0; j < WBUF_BYTES; j++) wb[j] <= wbuf[8*j +: 8];
            for (int j = 0; j < RBUF_BYTES; j++) rb[j] <= 8'h00;
        end else if (state == ST_ACCESS) begin
            if (is_read) begin
                for (int j = 0; j < RBUF_BYTES; j++) begin
                    if (j == 3 * int'(idx) + 2) rb[j] <= bus_rdata;
                end
            end
            if (is_rmw) hold <= bus_rdata;
        end
    end

    genvar g;
    generate
        for (g = 0; g < RBUF_BYTES; g++) begin : g_rbuf
            assign rbuf[8*g +: 8] = rb[g];
        end
    endgenerate

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FINISH);

    // R8: completion is a single-cycle pulse.
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4 / R5: a rejected command issues no bus access afterwards.
    a_r4_reject_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !busy && dec_code != ERR_NONE) |=> !(bus_re || bus_we));

    // R3: the merge write always follows a read of the same entry.
    a_r3_merge_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MERGE) |-> ($past(bus_re) && $stable(idx)));

    // R1: at most one register-bus access per cycle.
    a_r1_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_re && bus_we));

    // R7: the entry index never passes the decoded count while accessing.
    a_r7_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re || bus_we) |-> (idx < cnt));

endmodule

// File: rtl/regcmd_engine.sv
`timescale 1ns/1ps
// Top of the batched register-access command engine. It accepts a command of
// code 0xFF while idle, decodes the entry layout and count, runs the sequencer
// against the register-space model, and reports done, an error flag and an
// error code. Assumes start is sampled only on clock edges where busy is low.
module regcmd_engine
    import regcmd_pkg::*;
#(
    parameter int          WBUF_BYTES = 20,
    parameter int          RBUF_BYTES = 16,
    parameter int          MAX_ENT    = 5,
    parameter int          REG_AW     = 5,
    parameter logic [15:0] REG_BASE   = 16'h5A00
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [7:0]              cmd_code,
    input  logic [3:0]              sub_cmd,
    input  logic [7:0]              size,
    input  logic [WBUF_BYTES*8-1:0] wbuf,
    output logic                    busy,
    output logic                    done,
    output logic                    err_flag,
    output logic [7:0]              err_code,
    output logic [RBUF_BYTES*8-1:0] rbuf
);

    localparam int CNT_W = $clog2(MAX_ENT + 1);

    logic             accept;
    logic [CNT_W-1:0] dec_count;
    logic [7:0]       dec_code;
    logic             bus_re;
    logic             bus_we;
    logic [15:0]      bus_addr;
    logic [7:0]       bus_wdata;
    logic [7:0]       bus_rdata;

    assign accept = start && !busy && (cmd_code == CMD_REGACC);

    regcmd_decode #(
        .MAX_ENT (MAX_ENT),
        .CNT_W   (CNT_W)
    ) u_decode (
        .sub   (sub_cmd),
        .size  (size),
        .count (dec_count),
        .code  (dec_code)
    );

    regcmd_seq #(
        .WBUF_BYTES (WBUF_BYTES),
        .RBUF_BYTES (RBUF_BYTES),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .sub       (sub_cmd),
        .dec_count (dec_count),
        .dec_code  (dec_code),
        .wbuf      (wbuf),
        .bus_re    (bus_re),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .err_flag  (err_flag),
        .err_code  (err_code),
        .rbuf      (rbuf)
    );

    regcmd_regfile #(
        .AW   (REG_AW),
        .BASE (REG_BASE)
    ) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .re    (bus_re),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata)
    );

    // R6: a start carrying another command code leaves the engine idle.
    a_r6_other_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd_code != CMD_REGACC) |=> !busy);

    // R8: once busy, the engine stays busy until its done cycle.
    a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/regcmd_engine_bench.sv
`timescale 1ns/1ps
module regcmd_engine_bench;

    localparam logic [15:0] BASE = 16'h5A00;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   cmd_code = 8'h00;
    logic [3:0]   sub_cmd = 4'd0;
    logic [7:0]   size = 8'd0;
    logic [159:0] wbuf = '0;
    logic         busy, done, err_flag;
    logic [7:0]   err_code;
    logic [127:0] rbuf;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic [7:0]  sh [32];
    logic [7:0]  bbuf [20];

    always #2.5 clk = ~clk;

    regcmd_engine u_regcmd_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
        .sub_cmd(sub_cmd), .size(size), .wbuf(wbuf), .busy(busy), .done(done),
        .err_flag(err_flag), .err_code(err_code), .rbuf(rbuf)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [7:0] sh_read(input logic [15:0] a);
        return (a[15:5] == BASE[15:5]) ? sh[a[4:0]] : 8'h00;
    endfunction

    task automatic sh_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15:5] == BASE[15:5]) sh[a[4:0]] = d;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Fill the buffer with random bytes and mostly in-window addresses.
    task automatic fill_rand(input int width);
        logic [31:0] r;
        int w;
        w = (width == 0) ? 3 : width;
        for (int i = 0; i < 20; i++) bbuf[i] = rnd() >> 8;
        for (int e = 0; e * w + 1 < 20; e++) begin
            r = rnd();
            bbuf[e*w]   = (r[3:0] == 4'd1) ? r[23:16] : {3'b000, r[20:16]};
            bbuf[e*w+1] = (r[3:0] == 4'd0) ? r[15:8] : 8'h5A;
        end
    endtask

    // Issue one accepted command and compare every result with the model.
    task automatic do_cmd(input logic [3:0] sub, input logic [7:0] sz, input string rtag);
        int width, n, acc, lat;
        logic [7:0] exp_code, old, v, m;
        logic [15:0] a;
        logic [127:0] exp_rb;
        width = (sub == 4'd0) ? 3 : (sub == 4'd1) ? 2 : (sub == 4'd2) ? 4 : 0;
        exp_code = 8'h00;
        n = 0;
        if (width == 0) exp_code = 8'h02;
        else begin
            n = int'(sz) / width;
            if ((int'(sz) % width) != 0 || n > 5) exp_code = 8'h01;
        end
        acc = 0;
        exp_rb = '0;
        if (exp_code == 8'h00) begin
            for (int e = 0; e < n; e++) begin
                a = {bbuf[e*width+1], bbuf[e*width]};
                if (sub == 4'd0) begin
                    sh_write(a, bbuf[e*width+2]);
                    acc++;
                end else if (sub == 4'd1) begin
                    exp_rb[8*(2+3*e) +: 8] = sh_read(a);
                    acc++;
                end else begin
                    v = bbuf[e*width+2];
                    m = bbuf[e*width+3];
                    old = sh_read(a);
                    sh_write(a, (old & ~m) | (v & m));
                    acc += 2;
                end
            end
        end
        for (int i = 0; i < 20; i++) wbuf[8*i +: 8] = bbuf[i];
        cmd_code = 8'hFF;
        sub_cmd = sub;
        size = sz;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (done !== 1'b1 && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk("R8", "latency", 128'(lat), 128'(1 + acc));
        chk("R8", "busy in done cycle", 128'(busy), 128'(1));
        chk((exp_code == 8'h02) ? "R5" : "R4", "err_flag", 128'(err_flag), 128'(exp_code != 8'h00));
        chk((exp_code == 8'h02) ? "R5" : "R4", "err_code", 128'(err_code), 128'(exp_code));
        chk(rtag, "rbuf", rbuf, exp_rb);
        @(negedge clk);
        chk("R8", "done after pulse", 128'(done), 128'(0));
        chk("R8", "busy after done", 128'(busy), 128'(0));
    endtask

    // Read back the full window plus out-of-window addresses.
    task automatic verify_all(input string rtag);
        for (int b = 0; b < 32; b += 5) begin
            int k;
            k = 0;
            for (int j = 0; j < 5; j++) begin
                if (b + j < 32) begin
                    bbuf[2*j]   = 8'(b + j);
                    bbuf[2*j+1] = 8'h5A;
                    k++;
                end
            end
            do_cmd(4'd1, 8'(2 * k), rtag);
        end
        bbuf[0] = 8'h00; bbuf[1] = 8'h5B;
        bbuf[2] = 8'h20; bbuf[3] = 8'h5A;
        bbuf[4] = 8'hFF; bbuf[5] = 8'h5A;
        bbuf[6] = 8'h03; bbuf[7] = 8'h00;
        bbuf[8] = 8'hFF; bbuf[9] = 8'hFF;
        do_cmd(4'd1, 8'd10, "R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] prev;
        for (int i = 0; i < 32; i++) sh[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "busy after reset", 128'(busy), 128'(0));
        chk("R10", "done after reset", 128'(done), 128'(0));
        chk("R10", "err_flag after reset", 128'(err_flag), 128'(0));
        chk("R10", "err_code after reset", 128'(err_code), 128'(0));
        chk("R10", "rbuf after reset", rbuf, '0);
        verify_all("R9");

        // Exhaustive size sweep on each layout with random content.
        for (int s = 0; s < 4; s++) begin
            for (int z = 0; z <= 24; z++) begin
                fill_rand((s == 0) ? 3 : (s == 1) ? 2 : (s == 2) ? 4 : 0);
                do_cmd(4'(s), 8'(z), (s == 1) ? "R2" : "R4");
            end
            verify_all((s == 0) ? "R1" : (s == 2) ? "R3" : "R4");
        end

        // Unknown sub-commands with valid-looking sizes.
        for (int s = 3; s < 16; s++) begin
            fill_rand(3);
            do_cmd(4'(s), 8'd6, "R5");
        end
        verify_all("R5");

        // Other command codes are ignored.
        prev = rbuf;
        fill_rand(3);
        for (int i = 0; i < 20; i++) wbuf[8*i +: 8] = bbuf[i];
        cmd_code = 8'hFE; sub_cmd = 4'd0; size = 8'd9; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 6; c++) begin
            chk("R6", "done on other code", 128'(done), 128'(0));
            chk("R6", "busy on other code", 128'(busy), 128'(0));
            @(negedge clk);
        end
        chk("R6", "rbuf kept", rbuf, prev);
        verify_all("R6");

        // Ordering: last write to one address wins.
        bbuf[0] = 8'h03; bbuf[1] = 8'h5A; bbuf[2] = 8'h11;
        bbuf[3] = 8'h03; bbuf[4] = 8'h5A; bbuf[5] = 8'h22;
        bbuf[6] = 8'h03; bbuf[7] = 8'h5A; bbuf[8] = 8'h33;
        bbuf[9] = 8'h07; bbuf[10] = 8'h5A; bbuf[11] = 8'h00;
        do_cmd(4'd0, 8'd12, "R7");
        bbuf[0] = 8'h03; bbuf[1] = 8'h5A;
        do_cmd(4'd1, 8'd2, "R7");
        chk("R7", "last write wins", 128'(rbuf[23:16]), 128'(8'h33));

        // Ordering: chained read-modify-writes build on each other.
        bbuf[0] = 8'h07; bbuf[1] = 8'h5A; bbuf[2] = 8'hAB; bbuf[3] = 8'hF0;
        bbuf[4] = 8'h07; bbuf[5] = 8'h5A; bbuf[6] = 8'h5C; bbuf[7] = 8'h0F;
        do_cmd(4'd2, 8'd8, "R7");
        bbuf[0] = 8'h07; bbuf[1] = 8'h5A;
        do_cmd(4'd1, 8'd2, "R7");
        chk("R7", "chained merge", 128'(rbuf[23:16]), 128'(8'hAC));

        // Merge ends: mask 0x00 keeps, mask 0xFF replaces.
        bbuf[0] = 8'h07; bbuf[1] = 8'h5A; bbuf[2] = 8'h55; bbuf[3] = 8'h00;
        bbuf[4] = 8'h08; bbuf[5] = 8'h5A; bbuf[6] = 8'h96; bbuf[7] = 8'hFF;
        do_cmd(4'd2, 8'd8, "R3");
        bbuf[0] = 8'h07; bbuf[1] = 8'h5A; bbuf[2] = 8'h08; bbuf[3] = 8'h5A;
        do_cmd(4'd1, 8'd4, "R3");
        chk("R3", "mask zero keeps", 128'(rbuf[23:16]), 128'(8'hAC));
        chk("R3", "mask ones replaces", 128'(rbuf[47:40]), 128'(8'h96));
        verify_all("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule